// File: doc/BRIEF.md
# Two-Write Mailbox Bootstrap Doorbell

This block is the device side of a doorbell register through which a host posts a management command before any command rings exist. The host writes the register twice. The first write, with the hi flag set, carries the upper half of the mailbox address. The second write, with the hi flag clear, carries the lower half. After each accepted write the ready bit drops. After the first write it rises again once the upper half has been taken in. After the second write it rises only when an external command engine reports that the command is complete.

The 32-bit register is laid out as follows: bit 0 is ready, bit 1 is the hi flag, and bits 31:2 are a 30-bit address field. The assembled mailbox byte address is 64 bits wide. Bits 63:34 are the upper field, bits 33:4 are the lower field, and bits 3:0 are zero, so the mailbox is 16-byte aligned. A one-cycle start strobe tells the command engine that a complete address is available. A hi-clear write that arrives without a stored upper half raises a sequence-error flag and starts no command.

Top module: `mbx_boot_doorbell`

## Requirements
- R1: After reset, ready is 1, cmdStart is 0, seqErr is 0, and no upper half is held. A hi-clear write made straight after reset is therefore treated as out of sequence.
- R2: rdData always returns ready in bit 0 and zero in bits 31:1.
- R3: A write accepted with hi (wrData[1]) = 1 drives ready to 0 for exactly ACK_DELAY cycles (default 2). Ready then returns to 1, and the upper field wrData[31:2] is held as the upper half.
- R4: A write accepted with hi = 0 while an upper half is held raises cmdStart for exactly one cycle, in the cycle after the write. From that cycle on, mboxAddr equals {upper, wrData[31:2], 4'b0000} and holds that value until the next command starts.
- R5: After a command starts, ready stays 0 until cmdDone is sampled high, and it is 1 in the following cycle.
- R6: A hi = 0 write accepted while no upper half is held sets seqErr. It produces no cmdStart, and ready stays 1.
- R7: Writes made while ready is 0 are ignored. They do not change mboxAddr, the held upper half or the state, and they produce no cmdStart.
- R8: Completion of a command discards the held upper half, so the next hi = 0 write without a new hi = 1 write is out of sequence.
- R9: An accepted hi = 1 write clears seqErr. A second hi = 1 write before the lower half replaces the held upper half.
- R10: Bit 0 of write data has no effect on the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 32 | Write data: bits 31:2 are the address field, bit 1 is hi, bit 0 is ignored |
| rdData | output | 32 | Read value: ready in bit 0, zero elsewhere |
| cmdDone | input | 1 | Command engine reports completion |
| mboxAddr | output | 64 | Assembled 16-byte-aligned mailbox byte address |
| cmdStart | output | 1 | One-cycle command start strobe |
| seqErr | output | 1 | A lower half arrived without an upper half |

## Verification
The main handshake is driven with address pairs of all zeros, all ones, alternating bit patterns and single set bits. These patterns separate the two halves in the assembled address and expose any swapped, shifted or truncated field. Some pairs set write bit 0 and others clear it, which shows that bit 0 has no effect. Directed sequences cover the following cases: an orphan lower write straight after reset, writes made while the command is busy, a second upper write that replaces the first, and a lower write after completion with no new upper write. Together these tell an ignored write apart from an accepted one, and a held upper half apart from a discarded one.

// File: rtl/mbx_boot_pkg.sv
package mbx_boot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_BUSY = 2'd2
  } mbxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeUpper;   // capture upper field
    logic takeLower;   // capture lower field, assemble address
    logic flagOrphan;  // lower write with no upper half held
    logic dropUpper;   // command completed, forget upper half
  } mbxStrobe_t;

endpackage

// File: rtl/mbx_boot_ctrl.sv
module mbx_boot_ctrl
  import mbx_boot_pkg::*;
#(
  parameter int ACK_DELAY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       wrHi,
  input  logic       cmdDone,
  input  logic       upperValid,
  output logic       ready,
  output logic       cmdStart,
  output mbxStrobe_t strobe
);

  localparam int CNT_W = $clog2(ACK_DELAY + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(ACK_DELAY - 1);

  mbxState_t        state;
  logic [CNT_W-1:0] ackCnt;
  logic             accept;

  assign ready  = (state == ST_IDLE);
  assign accept = wrEn && ready;

  always_comb begin
    strobe            = '0;
    strobe.takeUpper  = accept && wrHi;
    strobe.takeLower  = accept && !wrHi && upperValid;
    strobe.flagOrphan = accept && !wrHi && !upperValid;
    strobe.dropUpper  = (state == ST_BUSY) && cmdDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      ackCnt   <= '0;
      cmdStart <= 1'b0;
    end else begin
      cmdStart <= strobe.takeLower;
      unique case (state)
        ST_IDLE: begin
          if (strobe.takeUpper) begin
            state  <= ST_ACK;
            ackCnt <= CNT_LOAD;
          end else if (strobe.takeLower) begin
            state <= ST_BUSY;
          end
        end
        ST_ACK: begin
          if (ackCnt == '0) state <= ST_IDLE;
          else              ackCnt <= ackCnt - 1'b1;
        end
        ST_BUSY: begin
          if (cmdDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: a start strobe only follows an accepted hi-clear write
  assert_start_after_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |-> $past(wrEn && ready && !wrHi));

  // R4: the start strobe lasts a single cycle
  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    cmdStart |=> !cmdStart);

  // R5: ready rises only at completion or at the end of the upper-half acknowledge
  assert_ready_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> ($past(cmdDone) || $past(state == ST_ACK)));

endmodule

// File: rtl/mbx_boot_dp.sv
module mbx_boot_dp
  import mbx_boot_pkg::*;
#(
  parameter int FIELD_W    = 30,
  parameter int ALIGN_BITS = 4,
  localparam int ADDR_W    = 2 * FIELD_W + ALIGN_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] wrField,
  input  mbxStrobe_t         strobe,
  input  logic               readyIn,
  output logic               upperValid,
  output logic               seqErr,
  output logic [ADDR_W-1:0]  mboxAddr
);

  logic [FIELD_W-1:0] upperReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      upperReg   <= '0;
      upperValid <= 1'b0;
      seqErr     <= 1'b0;
      mboxAddr   <= '0;
    end else begin
      if (strobe.takeUpper) begin
        upperReg   <= wrField;
        upperValid <= 1'b1;
        seqErr     <= 1'b0;
      end
      if (strobe.takeLower) begin
        mboxAddr <= {upperReg, wrField, {ALIGN_BITS{1'b0}}};
      end
      if (strobe.flagOrphan) seqErr     <= 1'b1;
      if (strobe.dropUpper)  upperValid <= 1'b0;
    end
  end

  // R7: no capture while ready is low
  assert_hold_when_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    !readyIn |=> ($stable(upperReg) && $stable(mboxAddr)));

endmodule

// File: rtl/mbx_boot_doorbell.sv
module mbx_boot_doorbell #(
  parameter int DATA_W     = 32,
  parameter int ALIGN_BITS = 4,
  parameter int ACK_DELAY  = 2,
  localparam int FIELD_W   = DATA_W - 2,
  localparam int ADDR_W    = 2 * FIELD_W + ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              cmdDone,
  output logic [ADDR_W-1:0] mboxAddr,
  output logic              cmdStart,
  output logic              seqErr
);

  import mbx_boot_pkg::*;

  mbxStrobe_t strobe;
  logic       ready;
  logic       upperValid;
  logic       unusedWrBit;

  assign unusedWrBit = wrData[0];
  assign rdData      = {{(DATA_W-1){1'b0}}, ready};

  mbx_boot_ctrl #(.ACK_DELAY(ACK_DELAY)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrHi       (wrData[1]),
    .cmdDone    (cmdDone),
    .upperValid (upperValid),
    .ready      (ready),
    .cmdStart   (cmdStart),
    .strobe     (strobe)
  );

  mbx_boot_dp #(.FIELD_W(FIELD_W), .ALIGN_BITS(ALIGN_BITS)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .wrField    (wrData[DATA_W-1:2]),
    .strobe     (strobe),
    .readyIn    (ready),
    .upperValid (upperValid),
    .seqErr     (seqErr),
    .mboxAddr   (mboxAddr)
  );

  // R6: an out-of-sequence write never coincides with a command start
  assert_orphan_no_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(seqErr) |-> (!cmdStart && ready));

endmodule

// File: tb/mbx_boot_doorbell_bench.sv
module mbx_boot_doorbell_bench;

  localparam int ACK_DELAY = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        cmdDone = 1'b0;
  logic [63:0] mboxAddr;
  logic        cmdStart;
  logic        seqErr;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  mbx_boot_doorbell #(.ACK_DELAY(ACK_DELAY)) u_mbx_boot_doorbell (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .cmdDone(cmdDone), .mboxAddr(mboxAddr), .cmdStart(cmdStart), .seqErr(seqErr)
  );

  // {bit0 of write data, upper field, lower field}
  localparam logic [60:0] VEC [5] = '{
    {1'b0, 30'h00000000, 30'h00000000},
    {1'b1, 30'h3FFFFFFF, 30'h3FFFFFFF},
    {1'b0, 30'h2AAAAAAA, 30'h15555555},
    {1'b1, 30'h00000001, 30'h20000000},
    {1'b1, 30'h12345678, 30'h0ABCDEF0}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one-cycle write; returns at the negedge after the sampling edge
  task automatic doWrite(input logic [29:0] field, input bit hi, input bit b0);
    wrData = {field, hi, b0};
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
    wrData = '0;
  endtask

  task automatic waitReady(output int lowCycles);
    lowCycles = 0;
    while (rdData[0] == 1'b0 && lowCycles < 100) begin
      @(negedge clk);
      lowCycles++;
    end
  endtask

  task automatic complete();
    cmdDone = 1'b1;
    @(negedge clk);
    cmdDone = 1'b0;
  endtask

  initial begin
    int n;
    logic [63:0] heldAddr;
    repeat (3) @(negedge clk);
    // R1 / R2: reset state
    chk(rdData == 32'h1, "R1 ready after reset", 64'(rdData), 64'h1);
    chk(cmdStart == 1'b0 && seqErr == 1'b0, "R1 strobes idle", {cmdStart, seqErr}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdData == 32'h1, "R2 read value idle", 64'(rdData), 64'h1);

    // R1 / R6: orphan lower write straight after reset
    doWrite(30'h155, 1'b0, 1'b0);
    chk(seqErr == 1'b1, "R1 R6 orphan sets seqErr", 64'(seqErr), 64'h1);
    chk(cmdStart == 1'b0, "R6 orphan no start", 64'(cmdStart), 64'h0);
    chk(rdData == 32'h1, "R6 ready stays high", 64'(rdData), 64'h1);

    // table of address pairs
    for (int i = 0; i < 5; i++) begin
      logic [63:0] exp;
      exp = {VEC[i][59:30], VEC[i][29:0], 4'b0000};
      doWrite(VEC[i][59:30], 1'b1, VEC[i][60]);
      chk(rdData == 32'h0, "R2 R3 ready low after upper", 64'(rdData), 64'h0);
      chk(seqErr == 1'b0, "R9 upper write clears seqErr", 64'(seqErr), 64'h0);
      waitReady(n);
      chk(n == ACK_DELAY, "R3 acknowledge length", 64'(n), 64'(ACK_DELAY));
      doWrite(VEC[i][29:0], 1'b0, VEC[i][60]);
      chk(cmdStart == 1'b1, "R4 start pulse", 64'(cmdStart), 64'h1);
      chk(mboxAddr == exp, "R4 R10 assembled address", mboxAddr, exp);
      @(negedge clk);
      chk(cmdStart == 1'b0, "R4 start one cycle", 64'(cmdStart), 64'h0);
      repeat (3) @(negedge clk);
      chk(rdData == 32'h0, "R5 ready low while busy", 64'(rdData), 64'h0);
      complete();
      chk(rdData == 32'h1, "R5 ready after completion", 64'(rdData), 64'h1);
    end

    // R7: writes while busy are ignored
    doWrite(30'h0000AAAA, 1'b1, 1'b0);
    waitReady(n);
    doWrite(30'h0000BBBB, 1'b0, 1'b0);
    heldAddr = {30'h0000AAAA, 30'h0000BBBB, 4'b0};
    doWrite(30'h3000CCCC, 1'b1, 1'b0);
    chk(cmdStart == 1'b0, "R7 busy write no start", 64'(cmdStart), 64'h0);
    doWrite(30'h0000DDDD, 1'b0, 1'b0);
    chk(cmdStart == 1'b0, "R7 busy lower write no start", 64'(cmdStart), 64'h0);
    chk(mboxAddr == heldAddr, "R7 address unchanged", mboxAddr, heldAddr);
    chk(rdData == 32'h0, "R7 still busy", 64'(rdData), 64'h0);
    complete();

    // R8: upper half discarded at completion (and the busy hi write was not taken)
    doWrite(30'h00001111, 1'b0, 1'b0);
    chk(seqErr == 1'b1, "R8 lower after completion is orphan", 64'(seqErr), 64'h1);
    chk(cmdStart == 1'b0, "R8 no start", 64'(cmdStart), 64'h0);
    chk(mboxAddr == heldAddr, "R8 address unchanged", mboxAddr, heldAddr);

    // R9: second upper write replaces the first and clears seqErr
    doWrite(30'h01010101, 1'b1, 1'b0);
    chk(seqErr == 1'b0, "R9 seqErr cleared", 64'(seqErr), 64'h0);
    waitReady(n);
    doWrite(30'h02020202, 1'b1, 1'b1);
    waitReady(n);
    chk(n == ACK_DELAY, "R3 second acknowledge", 64'(n), 64'(ACK_DELAY));
    doWrite(30'h03030303, 1'b0, 1'b1);
    chk(mboxAddr == {30'h02020202, 30'h03030303, 4'b0}, "R9 upper replaced",
        mboxAddr, {30'h02020202, 30'h03030303, 4'b0});
    chk(cmdStart == 1'b1, "R4 start after replace", 64'(cmdStart), 64'h1);
    complete();
    chk(rdData == 32'h1, "R2 read value after run", 64'(rdData), 64'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'h0, 64'h1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule